// File: doc/BRIEF.md
# Reset Cause Status Tracker

This block sits beside a small processor core. It works out why the core last restarted or woke from a low-power mode, and which program address the core resumes from. Each cause arrives as a one-cycle pulse: power-on, brown-out, external master clear, watchdog time-out, reset instruction, stack overflow, stack underflow, interrupt wake and sleep entry. A two-bit mode input gives the core's power state when the pulse arrives. The same pulse has a different effect depending on that state. A watchdog time-out or an interrupt during idle or sleep is a wake, not a reset.

The block keeps an eight-bit sticky status byte. Software reads and rewrites it through a simple register port. Five of its bits are active-low cause indicators: hardware clears them, and software writes 1 to re-arm them. One cycle after a reset or wake is resolved, a restart strobe goes high for exactly one cycle and carries the resume address.

The controller has three states. OFF is the state after the hardware reset pin, before any power-on pulse. IDLE is the waiting state. STROBE presents the restart address. OFF moves to STROBE on a power-on pulse. IDLE and STROBE move to STROBE when the winning event restarts the core, and to IDLE otherwise.

Top module: `reset_cause_tracker`

## Requirements
- R1: While in OFF (after `rst_n` and before the first power-on pulse), every input except `ev_por` is ignored: `reg_rdata` reads 00h and `restart_vld` stays 0.
- R2: Status byte layout: bit7 software brown-out enable, bit6 stack-full, bit5 stack-underflow, bit4 reset-instruction (low = happened), bit3 time-out (low), bit2 power-down (low), bit1 power-on (low), bit0 brown-out (low). A power-on pulse sets bits 4..2 to 1, clears bits 6,5,1,0, and restarts at address 0.
- R3: When several pulses arrive in one cycle, only the highest-priority one acts. The order is power-on, brown-out, master clear, watchdog, reset instruction, stack-full, stack-underflow, interrupt wake, sleep entry, software write.
- R4: A brown-out pulse sets bits 4..2, clears bit0, leaves bit1 unchanged and restarts at 0.
- R5: A master clear restarts at 0. In full-power run (`pmode`=00) or low-power run (01) it leaves bits 6..0 unchanged. In idle (10) or sleep (11) it sets bit3 and clears bit2.
- R6: A watchdog pulse clears bit3. In run modes it restarts at 0. In idle or sleep it also clears bit2, keeps bit7 and resumes at `cur_pc`+2, wrapping modulo 2^PC_W.
- R7: A reset-instruction pulse clears bit4 and restarts at 0.
- R8: A stack-full or stack-underflow pulse sets bit6 or bit5. It restarts at 0 only when `stk_rst_en` is 1. Otherwise there is no strobe and the held restart address is unchanged.
- R9: An interrupt wake in idle or sleep clears bit2. It resumes at 0008h if `gie_hi` is 1, else at 0018h if `gie_lo` is 1, else at `cur_pc`+2. In run modes the pulse is ignored.
- R10: A sleep-entry pulse clears bit2 and gives no strobe.
- R11: When `bor_cfg` is 01, a power-on pulse sets bit7 and every other reset keeps it. For any other `bor_cfg`, every reset clears bit7.
- R12: A register write loads all eight status bits from `reg_wdata`, unless some event acts in the same cycle. In that case the write is dropped.
- R13: `restart_vld` is high exactly in the cycle after a restarting event, for one cycle, with `restart_pc` holding the resume address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset, enters OFF |
| ev_por | input | 1 | Power-on pulse |
| ev_bor | input | 1 | Brown-out pulse |
| ev_mclr | input | 1 | External master clear pulse |
| ev_wdt | input | 1 | Watchdog time-out pulse |
| ev_rsti | input | 1 | Reset instruction pulse |
| ev_stk_full | input | 1 | Stack overflow pulse |
| ev_stk_unf | input | 1 | Stack underflow pulse |
| ev_irq_wake | input | 1 | Interrupt wake pulse |
| ev_sleep | input | 1 | Sleep entry pulse |
| pmode | input | 2 | Power mode: 00 full run, 01 low-power run, 10 idle, 11 sleep |
| stk_rst_en | input | 1 | Stack faults force a reset when 1 |
| bor_cfg | input | 2 | Brown-out configuration; 01 selects software enable |
| gie_hi | input | 1 | High-priority global interrupt enable |
| gie_lo | input | 1 | Low-priority global interrupt enable |
| cur_pc | input | PC_W | Current program address |
| reg_we | input | 1 | Status write strobe |
| reg_wdata | input | 8 | Status write data |
| reg_rdata | output | 8 | Status byte |
| restart_vld | output | 1 | Restart strobe |
| restart_pc | output | PC_W | Resume address |

## Verification
The bench builds the block with PC_W = 16, which is narrower than the default. This makes the wrap of `cur_pc`+2 at the top of the address space reachable, on watchdog wakes and on interrupt wakes with both enables low. A fixed seed drives random pulse mixes in all four power modes and all brown-out configurations, so simultaneous pulses regularly test the priority chain. Directed cases cover OFF, each wake vector and the write-versus-event collision.

// File: rtl/rct_pkg.sv
package rct_pkg;

    localparam int NUM_EV = 9;
    localparam int IDX_W  = $clog2(NUM_EV);

    typedef enum logic [1:0] {
        PM_FULL   = 2'd0,
        PM_LOWRUN = 2'd1,
        PM_IDLE   = 2'd2,
        PM_SLEEP  = 2'd3
    } pmode_e;

    // Index order equals priority order (0 = highest)
    typedef enum logic [IDX_W-1:0] {
        EV_POR   = 4'd0,
        EV_BOR   = 4'd1,
        EV_MCLR  = 4'd2,
        EV_WDT   = 4'd3,
        EV_RSTI  = 4'd4,
        EV_SFULL = 4'd5,
        EV_SUNF  = 4'd6,
        EV_IRQ   = 4'd7,
        EV_SLEEP = 4'd8
    } cause_e;

    typedef struct packed {
        logic sw_bor_en;
        logic stk_full;
        logic stk_under;
        logic n_rinst;
        logic n_tmo;
        logic n_pdown;
        logic n_pwron;
        logic n_brown;
    } status_t;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_STROBE = 2'd2
    } fsm_e;

endpackage

// File: rtl/rct_prio.sv
module rct_prio #(
    parameter int N     = 9,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rct_resolve.sv
module rct_resolve
    import rct_pkg::*;
#(
    parameter int          PC_W      = 21,
    parameter int          PC_STEP   = 2,
    parameter int          RST_VEC   = 0,
    parameter int          HI_VEC    = 8,
    parameter int          LO_VEC    = 24,
    parameter logic [1:0]  SWBOR_CFG = 2'b01
) (
    input  cause_e          cause,
    input  logic            any,
    input  logic            halted,
    input  logic            stk_rst_en,
    input  logic [1:0]      bor_cfg,
    input  logic            gie_hi,
    input  logic            gie_lo,
    input  logic [PC_W-1:0] cur_pc,
    input  status_t         cur,
    output status_t         nxt,
    output logic            restart,
    output logic [PC_W-1:0] rpc
);
    localparam logic [PC_W-1:0] RST_PC = PC_W'(RST_VEC);
    localparam logic [PC_W-1:0] HI_PC  = PC_W'(HI_VEC);
    localparam logic [PC_W-1:0] LO_PC  = PC_W'(LO_VEC);

    logic            sw_cfg;
    logic            keep_sb;
    logic [PC_W-1:0] wake_pc;

    assign sw_cfg  = (bor_cfg == SWBOR_CFG);
    assign keep_sb = sw_cfg ? cur.sw_bor_en : 1'b0;
    assign wake_pc = cur_pc + PC_W'(PC_STEP);

    always_comb begin
        nxt     = cur;
        restart = 1'b0;
        rpc     = RST_PC;
        if (any) begin
            unique case (cause)
                EV_POR: begin
                    nxt.sw_bor_en = sw_cfg;
                    nxt.stk_full  = 1'b0;
                    nxt.stk_under = 1'b0;
                    nxt.n_rinst   = 1'b1;
                    nxt.n_tmo     = 1'b1;
                    nxt.n_pdown   = 1'b1;
                    nxt.n_pwron   = 1'b0;
                    nxt.n_brown   = 1'b0;
                    restart       = 1'b1;
                end
                EV_BOR: begin
                    nxt.sw_bor_en = keep_sb;
                    nxt.n_rinst   = 1'b1;
                    nxt.n_tmo     = 1'b1;
                    nxt.n_pdown   = 1'b1;
                    nxt.n_brown   = 1'b0;
                    restart       = 1'b1;
                end
                EV_MCLR: begin
                    nxt.sw_bor_en = keep_sb;
                    if (halted) begin
                        nxt.n_tmo   = 1'b1;
                        nxt.n_pdown = 1'b0;
                    end
                    restart = 1'b1;
                end
                EV_WDT: begin
                    nxt.n_tmo = 1'b0;
                    restart   = 1'b1;
                    if (halted) begin
                        nxt.n_pdown = 1'b0;
                        rpc         = wake_pc;
                    end else begin
                        nxt.sw_bor_en = keep_sb;
                    end
                end
                EV_RSTI: begin
                    nxt.sw_bor_en = keep_sb;
                    nxt.n_rinst   = 1'b0;
                    restart       = 1'b1;
                end
                EV_SFULL, EV_SUNF: begin
                    if (cause == EV_SFULL) nxt.stk_full  = 1'b1;
                    else                   nxt.stk_under = 1'b1;
                    if (stk_rst_en) begin
                        nxt.sw_bor_en = keep_sb;
                        restart       = 1'b1;
                    end
                end
                EV_IRQ: begin
                    nxt.n_pdown = 1'b0;
                    restart     = 1'b1;
                    rpc         = gie_hi ? HI_PC : (gie_lo ? LO_PC : wake_pc);
                end
                EV_SLEEP: begin
                    nxt.n_pdown = 1'b0;
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/reset_cause_tracker.sv
module reset_cause_tracker
    import rct_pkg::*;
#(
    parameter int PC_W    = 21,
    parameter int PC_STEP = 2,
    parameter int HI_VEC  = 8,
    parameter int LO_VEC  = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_por,
    input  logic            ev_bor,
    input  logic            ev_mclr,
    input  logic            ev_wdt,
    input  logic            ev_rsti,
    input  logic            ev_stk_full,
    input  logic            ev_stk_unf,
    input  logic            ev_irq_wake,
    input  logic            ev_sleep,
    input  logic [1:0]      pmode,
    input  logic            stk_rst_en,
    input  logic [1:0]      bor_cfg,
    input  logic            gie_hi,
    input  logic            gie_lo,
    input  logic [PC_W-1:0] cur_pc,
    input  logic            reg_we,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    output logic            restart_vld,
    output logic [PC_W-1:0] restart_pc
);
    fsm_e            state_q, state_d;
    status_t         flags_q, flags_d;
    logic [PC_W-1:0] pc_q, rpc;
    logic [NUM_EV-1:0] raw_req, req;
    logic [IDX_W-1:0]  win_idx;
    logic            any, restart, halted, powered;
    pmode_e          mode;

    assign mode    = pmode_e'(pmode);
    assign halted  = (mode == PM_IDLE) || (mode == PM_SLEEP);
    assign powered = (state_q != ST_OFF);

    assign raw_req = {ev_sleep, ev_irq_wake & halted, ev_stk_unf, ev_stk_full,
                      ev_rsti, ev_wdt, ev_mclr, ev_bor, ev_por};
    assign req     = powered ? raw_req : {{(NUM_EV-1){1'b0}}, ev_por};

    rct_prio #(.N(NUM_EV), .IDX_W(IDX_W)) u_prio (
        .req (req),
        .idx (win_idx),
        .any (any)
    );

    rct_resolve #(
        .PC_W    (PC_W),
        .PC_STEP (PC_STEP),
        .HI_VEC  (HI_VEC),
        .LO_VEC  (LO_VEC)
    ) u_resolve (
        .cause      (cause_e'(win_idx)),
        .any        (any),
        .halted     (halted),
        .stk_rst_en (stk_rst_en),
        .bor_cfg    (bor_cfg),
        .gie_hi     (gie_hi),
        .gie_lo     (gie_lo),
        .cur_pc     (cur_pc),
        .cur        (flags_q),
        .nxt        (flags_d),
        .restart    (restart),
        .rpc        (rpc)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:             state_d = ev_por  ? ST_STROBE : ST_OFF;
            ST_IDLE, ST_STROBE: state_d = restart ? ST_STROBE : ST_IDLE;
            default:            state_d = ST_OFF;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            flags_q <= '0;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (any)
                flags_q <= flags_d;
            else if (reg_we && powered)
                flags_q <= status_t'(reg_wdata);
            if (restart)
                pc_q <= rpc;
        end
    end

    // Outputs
    always_comb begin
        reg_rdata   = flags_q;
        restart_vld = (state_q == ST_STROBE);
        restart_pc  = pc_q;
    end
endmodule

// File: rtl/rct_checker.sv
module rct_checker #(
    parameter int PC_W = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic            powered,
    input logic            ev_por,
    input logic            ev_bor,
    input logic            ev_mclr,
    input logic            ev_wdt,
    input logic            ev_rsti,
    input logic            ev_stk_full,
    input logic            ev_stk_unf,
    input logic            ev_irq_wake,
    input logic [1:0]      pmode,
    input logic [7:0]      reg_rdata,
    input logic            restart_vld,
    input logic [PC_W-1:0] restart_pc
);
    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !powered |-> (reg_rdata == 8'h00) && !restart_vld);

    assert_por_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_por) |-> restart_vld && (restart_pc == '0)
                          && (reg_rdata[6:0] == 7'b001_1100));

    assert_bor_mclr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(powered && (ev_bor || ev_mclr)) |-> restart_vld && (restart_pc == '0));

    assert_wdt_clears_to_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(powered && ev_wdt && !ev_por && !ev_bor && !ev_mclr)
            |-> !reg_rdata[3] && restart_vld);

    assert_run_irq_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_irq_wake && !pmode[1] && !ev_por && !ev_bor && !ev_mclr && !ev_wdt
              && !ev_rsti && !ev_stk_full && !ev_stk_unf) |-> !restart_vld);

    assert_strobe_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
        restart_vld |-> $past(ev_por || ev_bor || ev_mclr || ev_wdt || ev_rsti
                              || ev_stk_full || ev_stk_unf || ev_irq_wake));

    assert_strobe_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_vld && $past(restart_vld)) |-> $past(ev_por || ev_bor || ev_mclr || ev_wdt
              || ev_rsti || ev_stk_full || ev_stk_unf || ev_irq_wake));
endmodule

bind reset_cause_tracker rct_checker #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .powered     (powered),
    .ev_por      (ev_por),
    .ev_bor      (ev_bor),
    .ev_mclr     (ev_mclr),
    .ev_wdt      (ev_wdt),
    .ev_rsti     (ev_rsti),
    .ev_stk_full (ev_stk_full),
    .ev_stk_unf  (ev_stk_unf),
    .ev_irq_wake (ev_irq_wake),
    .pmode       (pmode),
    .reg_rdata   (reg_rdata),
    .restart_vld (restart_vld),
    .restart_pc  (restart_pc)
);

// File: tb/tb_reset_cause_tracker.sv
`timescale 1ns/1ps
module tb_reset_cause_tracker;
    localparam int PC_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_por, ev_bor, ev_mclr, ev_wdt, ev_rsti, ev_stk_full, ev_stk_unf, ev_irq_wake, ev_sleep;
    logic [1:0] pmode, bor_cfg;
    logic stk_rst_en, gie_hi, gie_lo, reg_we;
    logic [PC_W-1:0] cur_pc;
    logic [7:0] reg_wdata, reg_rdata;
    logic restart_vld;
    logic [PC_W-1:0] restart_pc;

    int checks = 0;
    int errors = 0;
    logic [7:0]      m_flags = 8'h00;
    logic [PC_W-1:0] m_pc = '0;
    logic            m_on = 1'b0;

    always #2 clk = ~clk;

    reset_cause_tracker #(.PC_W(PC_W)) dut (.*);

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic clear_in();
        {ev_por, ev_bor, ev_mclr, ev_wdt, ev_rsti, ev_stk_full, ev_stk_unf, ev_irq_wake, ev_sleep} = '0;
        reg_we = 1'b0;
    endtask

    // Model from the requirements; one clock, then compare at the negedge
    task automatic step(input string tag);
        logic [7:0] f; logic v; logic [PC_W-1:0] p; string t; string dt; logic sb; logic sw;
        f = m_flags; v = 1'b0; p = m_pc; t = tag; dt = "R13";
        sw = (bor_cfg == 2'b01);
        sb = sw ? m_flags[7] : 1'b0;
        if (!m_on) begin
            dt = "R1";
            if (ev_por) begin f = {sw, 7'h1C}; v = 1'b1; p = '0; m_on = 1'b1; dt = "R2"; end
        end else if (ev_por) begin
            f = {sw, 7'h1C}; v = 1'b1; p = '0; dt = "R2";
        end else if (ev_bor) begin
            f[4] = 1; f[3] = 1; f[2] = 1; f[0] = 0; f[7] = sb; v = 1; p = '0; dt = "R4";
        end else if (ev_mclr) begin
            if (pmode[1]) begin f[3] = 1; f[2] = 0; end
            f[7] = sb; v = 1; p = '0; dt = "R5";
        end else if (ev_wdt) begin
            f[3] = 0; v = 1; dt = "R6";
            if (pmode[1]) begin f[2] = 0; p = cur_pc + 16'd2; end
            else begin p = '0; f[7] = sb; end
        end else if (ev_rsti) begin
            f[4] = 0; f[7] = sb; v = 1; p = '0; dt = "R7";
        end else if (ev_stk_full) begin
            f[6] = 1; dt = "R8";
            if (stk_rst_en) begin v = 1; p = '0; f[7] = sb; end
        end else if (ev_stk_unf) begin
            f[5] = 1; dt = "R8";
            if (stk_rst_en) begin v = 1; p = '0; f[7] = sb; end
        end else if (ev_irq_wake && pmode[1]) begin
            f[2] = 0; v = 1; dt = "R9";
            p = gie_hi ? 16'h0008 : (gie_lo ? 16'h0018 : cur_pc + 16'd2);
        end else if (ev_sleep) begin
            f[2] = 0; dt = "R10";
        end else if (reg_we) begin
            f = reg_wdata; dt = "R12";
        end
        if (t == "") t = dt;
        @(posedge clk);
        @(negedge clk);
        check(t, "status", {24'h0, reg_rdata}, {24'h0, f});
        check(t, "strobe", {31'h0, restart_vld}, {31'h0, v});
        if (v) check(t, "address", {16'h0, restart_pc}, {16'h0, p});
        m_flags = f;
        m_pc = p;
        clear_in();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog: actual hang expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_in();
        pmode = 2'b00; bor_cfg = 2'b01; stk_rst_en = 0; gie_hi = 0; gie_lo = 0;
        cur_pc = 16'h0100; reg_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset status", {24'h0, reg_rdata}, 32'h0);
        check("R1", "reset strobe", {31'h0, restart_vld}, 32'h0);

        // R1: ignored while OFF
        ev_wdt = 1; ev_mclr = 1; reg_we = 1; reg_wdata = 8'hFF; step("R1");
        // R2: power-on with software brown-out enable
        ev_por = 1; step("R2");
        step("R13");
        // R12: software write re-arms flags
        reg_we = 1; reg_wdata = 8'h9F; step("R12");
        // R3: simultaneous pulses
        ev_bor = 1; ev_wdt = 1; ev_rsti = 1; step("R3");
        ev_wdt = 1; ev_rsti = 1; ev_irq_wake = 1; pmode = 2'b11; step("R3");
        // R5: master clear run vs sleep
        pmode = 2'b01; ev_mclr = 1; step("R5");
        pmode = 2'b10; ev_mclr = 1; step("R5");
        // R6: watchdog wake with address wrap
        pmode = 2'b11; cur_pc = 16'hFFFF; ev_wdt = 1; step("R6");
        pmode = 2'b00; ev_wdt = 1; step("R6");
        // R9: interrupt wake vectors and run-mode ignore
        pmode = 2'b11; gie_hi = 1; gie_lo = 1; ev_irq_wake = 1; step("R9");
        gie_hi = 0; ev_irq_wake = 1; step("R9");
        gie_lo = 0; cur_pc = 16'hFFFE; ev_irq_wake = 1; step("R9");
        pmode = 2'b00; reg_we = 1; reg_wdata = 8'h1F; step("R12");
        ev_irq_wake = 1; step("R9");
        // R8: stack faults
        stk_rst_en = 0; ev_stk_unf = 1; step("R8");
        ev_stk_full = 1; step("R8");
        stk_rst_en = 1; ev_stk_unf = 1; step("R8");
        // R10, R7, R4
        ev_sleep = 1; step("R10");
        ev_rsti = 1; step("R7");
        ev_bor = 1; step("R4");
        // R11: other configuration clears the enable
        bor_cfg = 2'b00; ev_rsti = 1; step("R11");
        bor_cfg = 2'b01; ev_por = 1; step("R11");
        // R12: event beats write
        reg_we = 1; reg_wdata = 8'h00; ev_sleep = 1; step("R12");

        for (int i = 0; i < 3000; i++) begin
            ev_por      = ($urandom % 64) == 0;
            ev_bor      = ($urandom % 24) == 0;
            ev_mclr     = ($urandom % 16) == 0;
            ev_wdt      = ($urandom % 12) == 0;
            ev_rsti     = ($urandom % 16) == 0;
            ev_stk_full = ($urandom % 16) == 0;
            ev_stk_unf  = ($urandom % 16) == 0;
            ev_irq_wake = ($urandom % 8) == 0;
            ev_sleep    = ($urandom % 8) == 0;
            reg_we      = ($urandom % 6) == 0;
            reg_wdata   = 8'($urandom);
            pmode       = 2'($urandom);
            bor_cfg     = 2'($urandom);
            stk_rst_en  = 1'($urandom);
            gie_hi      = 1'($urandom);
            gie_lo      = 1'($urandom);
            cur_pc      = 16'($urandom);
            step("");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule